// File: doc/BRIEF.md
# Serial Port with Control Register

This block is a full-duplex asynchronous serial port driven through a small register window. An 8-bit control register selects the operating mode, enables the receiver and holds two sticky completion flags. A second address reaches a data buffer. Writing the buffer sends a byte, and reading it returns the last byte that was received. Only the 10-bit frame is implemented: one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line idles high.

Bit timing comes from `os_tick`, an enable pulse at OVERSAMPLE times the bit rate. Each bit lasts OVERSAMPLE ticks. The receiver brings the line through a synchroniser chain and samples it on these ticks. It confirms the start bit at mid-bit and takes every later bit from its middle sample. The completion flags are combined into a single interrupt request for the system interrupt controller.

Top module: `sio_port`

## Requirements
- R1: After reset `ser_out` is 1, `sio_irq` is 0, and the control register and receive buffer both read 0.
- R2: `reg_addr`=0 selects the control register and `reg_addr`=1 the data buffer. In the control register, bits 7:6 are the mode field (value 01 is the only operating mode), bit 4 enables reception, bit 1 is the transmit flag and bit 0 is the receive flag. A write stores all eight bits, and the value written reads back unchanged.
- R3: A buffer write in mode 01 with the transmitter idle starts a frame. `ser_out` goes low on the next clock. Each bit position then lasts OVERSAMPLE ticks, counted from the write: start, data bit 0 to data bit 7, then stop (high).
- R4: The transmit flag (bit 1) is set on the clock edge where the stop bit begins. The next buffer write is accepted once the stop bit has lasted OVERSAMPLE ticks.
- R5: A buffer write is ignored while a frame is in progress, including during its stop bit, and is also ignored when the mode field is not 01.
- R6: The line passes through SYNC_STAGES flops. In the idle state, a low line seen on a tick starts a frame. If the line is high on the OVERSAMPLE/2-th tick after that, the frame is dropped as a false start.
- R7: Data bit b is sampled on tick OVERSAMPLE/2 + OVERSAMPLE·(b+1) after start detection, least significant bit first. The stop bit is sampled on tick OVERSAMPLE/2 + 9·OVERSAMPLE. If the stop sample is high and bit 0 is clear, the byte is loaded into the receive buffer and bit 0 is set on that same edge.
- R8: A frame whose stop sample is low is discarded. Bit 0 and the buffer do not change.
- R9: A frame that completes while bit 0 is still set is discarded, and the buffer keeps the earlier byte.
- R10: The receiver ignores the line when bit 4 is 0 or the mode field is not 01. Clearing bit 4 during a frame abandons that frame.
- R11: Once set, bits 0 and 1 stay set until a control register write clears them.
- R12: `sio_irq` is 1 exactly when bit 0 or bit 1 of the control register is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = data buffer |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected address |
| os_tick | input | 1 | Enable pulse at OVERSAMPLE times the bit rate |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line |
| sio_irq | output | 1 | Interrupt request, OR of the two flags |

## Verification
The bench builds the block with OVERSAMPLE=16 and SYNC_STAGES=2 and drives `os_tick` on every second clock. One frame therefore spans 320 clocks, and the receiver's mid-bit sampling stays within one tick of true centre. That leaves room for sampling skew and for late starts. A loopback of `ser_out` onto `ser_in` puts both the transmit flag timing and the ignored mid-frame writes within reach of the receive path. Directed line patterns cover the remaining receive cases: stop bit low, a short false start, a byte arriving while the receive flag is set, and the receiver disabled or switched off mid-frame.

// File: rtl/sio_pkg.sv
package sio_pkg;
   localparam int BYTE_W = 8;
   localparam int CTL_RX_FLAG = 0;
   localparam int CTL_TX_FLAG = 1;
   localparam int CTL_RX_EN = 4;
   localparam int CTL_MODE_LO = 6;
   localparam logic [1:0] MODE_ASYNC10 = 2'b01;
   localparam int LAST_DATA_POS = BYTE_W;
   localparam int STOP_POS = BYTE_W + 1;

   typedef enum logic {RX_IDLE = 1'b0, RX_RUN = 1'b1} rx_state_e;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sio_tx.sv
module sio_tx
   import sio_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_data,
   output logic              busy,
   output logic              stop_enter,
   output logic              line
);
   localparam int CW = $clog2(OVERSAMPLE);
   localparam logic [CW-1:0] TCNT_LAST = CW'(OVERSAMPLE - 1);

   logic [BYTE_W-1:0] hold;
   logic [3:0]        pos;
   logic [CW-1:0]     tcnt;
   logic              bit_end;
   logic              next_level;

   assign bit_end    = busy && tick && (tcnt == TCNT_LAST);
   assign stop_enter = bit_end && (pos == 4'(LAST_DATA_POS));
   assign next_level = (pos < 4'(LAST_DATA_POS)) ? hold[pos[2:0]] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         line <= 1'b1;
         hold <= '0;
         pos  <= '0;
         tcnt <= '0;
      end else if (!busy) begin
         if (load) begin
            busy <= 1'b1;
            hold <= load_data;
            pos  <= '0;
            tcnt <= '0;
            line <= 1'b0;
         end
      end else if (tick) begin
         if (tcnt == TCNT_LAST) begin
            tcnt <= '0;
            if (pos == 4'(STOP_POS)) begin
               busy <= 1'b0;
               line <= 1'b1;
            end else begin
               pos  <= pos + 4'd1;
               line <= next_level;
            end
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   // R3: a frame opens with a low start bit
   p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !line);
   // R3: the line is high whenever no frame is in flight
   p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> line);
   // R5: a load during a frame leaves the byte being sent untouched
   p_load_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && load) |=> $stable(hold));
   // R4: entering the stop bit drives the line high
   p_stop_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stop_enter |=> (line && busy));
endmodule

// File: rtl/sio_rx.sv
module sio_rx
   import sio_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              enable,
   input  logic              line,
   input  logic              hold_full,
   output logic              done,
   output logic              active,
   output logic [BYTE_W-1:0] data
);
   localparam int CW = $clog2(OVERSAMPLE);
   localparam logic [CW-1:0] RCNT_LAST = CW'(OVERSAMPLE - 1);
   localparam logic [CW-1:0] RCNT_MID  = CW'(OVERSAMPLE / 2 - 1);

   rx_state_e     state;
   logic [CW-1:0] rcnt;
   logic [3:0]    pos;
   logic          mid;

   assign active = (state == RX_RUN);
   assign mid    = active && enable && tick && (rcnt == RCNT_MID);
   assign done   = mid && (pos == 4'(STOP_POS)) && line && !hold_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= RX_IDLE;
         rcnt  <= '0;
         pos   <= '0;
         data  <= '0;
      end else if (!enable) begin
         state <= RX_IDLE;
      end else if (tick) begin
         if (state == RX_IDLE) begin
            if (!line) begin
               state <= RX_RUN;
               rcnt  <= '0;
               pos   <= '0;
            end
         end else begin
            rcnt <= (rcnt == RCNT_LAST) ? '0 : rcnt + 1'b1;
            if (rcnt == RCNT_LAST) pos <= pos + 4'd1;
            if (rcnt == RCNT_MID) begin
               if (pos == 4'd0) begin
                  if (line) state <= RX_IDLE;
               end else if (pos == 4'(STOP_POS)) begin
                  state <= RX_IDLE;
               end else begin
                  data <= {line, data[BYTE_W-1:1]};
               end
            end
         end
      end
   end

   // R10: the receiver drops out of a frame when it is disabled
   p_off_when_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !active);
   // R6: a frame only starts after a low line
   p_start_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(!line));
endmodule

// File: rtl/sio_port.sv
module sio_port
   import sio_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_we,
   input  logic       reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       os_tick,
   input  logic       ser_in,
   output logic       ser_out,
   output logic       sio_irq
);
   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("sio_port: OVERSAMPLE must be even and at least 4");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("sio_port: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [7:0]        ctrl, ctrl_next;
   logic [BYTE_W-1:0] rxbuf;
   logic              mode_ok, ctrl_wr, buf_wr;
   logic              line_sync;
   logic              tx_busy, tx_stop;
   logic              rx_done, rx_active;
   logic [BYTE_W-1:0] rx_data;

   assign mode_ok = (ctrl[CTL_MODE_LO+1:CTL_MODE_LO] == MODE_ASYNC10);
   assign ctrl_wr = reg_we && !reg_addr;
   assign buf_wr  = reg_we && reg_addr && mode_ok;

   sio_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ser_in), .q(line_sync)
   );

   sio_tx #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .load(buf_wr),
      .load_data(reg_wdata), .busy(tx_busy), .stop_enter(tx_stop),
      .line(ser_out)
   );

   sio_rx #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(os_tick),
      .enable(ctrl[CTL_RX_EN] && mode_ok), .line(line_sync),
      .hold_full(ctrl[CTL_RX_FLAG]), .done(rx_done), .active(rx_active),
      .data(rx_data)
   );

   always_comb begin
      ctrl_next = ctrl_wr ? reg_wdata : ctrl;
      if (tx_stop) ctrl_next[CTL_TX_FLAG] = 1'b1;
      if (rx_done) ctrl_next[CTL_RX_FLAG] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl  <= '0;
         rxbuf <= '0;
      end else begin
         ctrl <= ctrl_next;
         if (rx_done) rxbuf <= rx_data;
      end
   end

   assign sio_irq   = ctrl[CTL_RX_FLAG] | ctrl[CTL_TX_FLAG];
   assign reg_rdata = reg_addr ? rxbuf : ctrl;

   // R4: entering the stop bit raises the transmit flag
   p_tx_flag_at_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_stop |=> ctrl[CTL_TX_FLAG]);
   // R7: a completed frame lands in the buffer with the receive flag
   p_rx_byte_loaded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> (ctrl[CTL_RX_FLAG] && rxbuf == $past(rx_data)));
   // R9: the buffer holds while the receive flag is set
   p_buf_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[CTL_RX_FLAG] |=> $stable(rxbuf));
   // R11: flags survive until a control write
   p_rx_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[CTL_RX_FLAG] && !ctrl_wr) |=> ctrl[CTL_RX_FLAG]);
   p_tx_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[CTL_TX_FLAG] && !ctrl_wr) |=> ctrl[CTL_TX_FLAG]);
   // R5: no frame starts outside mode 01
   p_no_tx_bad_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_ok && !tx_busy) |=> !tx_busy);
   // R10: the receiver stays idle while disabled
   p_rx_idle_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl[CTL_RX_EN] && mode_ok) |=> !rx_active);
endmodule

// File: tb/sio_port_tb.sv
`timescale 1ns/1ps
module sio_port_tb;
   localparam int OS = 16;
   localparam int SYNC = 2;
   localparam int BITCLK = 2 * OS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       we = 1'b0;
   logic       addr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       rx_drv = 1'b1;
   logic       loop = 1'b0;
   logic       cmp_on = 1'b0;
   logic       ser_in;
   logic       ser_out, irq;
   logic [7:0] rdata;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   assign ser_in = loop ? ser_out : rx_drv;

   sio_port #(.OVERSAMPLE(OS), .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .os_tick(tick),
      .ser_in(ser_in), .ser_out(ser_out), .sio_irq(irq)
   );

   always #2.5 clk = ~clk;
   always @(negedge clk) tick <= rst_n ? ~tick : 1'b0;

   // behavioural reference model
   logic [7:0] m_ctrl, m_buf, m_tx, m_byte;
   int  m_k, m_rt;
   bit  m_busy, m_txd;
   bit  sq[$];

   always @(posedge clk) begin
      bit line, s, ok, ren, acc, set_ti, set_ri;
      int b, idx;
      if (!rst_n) begin
         m_ctrl = 0; m_buf = 0; m_tx = 0; m_byte = 0;
         m_k = 0; m_rt = -1; m_busy = 0; m_txd = 1;
         sq = {};
         for (int i = 0; i < SYNC; i++) sq.push_back(1'b1);
      end else begin
         line = loop ? m_txd : rx_drv;
         s = sq[0];
         void'(sq.pop_front());
         sq.push_back(line);
         ok = (m_ctrl[7:6] == 2'b01);
         ren = m_ctrl[4];
         set_ti = 0; set_ri = 0;
         if (!(ren && ok)) m_rt = -1;
         else if (tick) begin
            if (m_rt < 0) begin
               if (!s) m_rt = 0;
            end else begin
               m_rt++;
               if (m_rt % OS == OS / 2) begin
                  b = m_rt / OS;
                  if (b == 0) begin
                     if (s) m_rt = -1;
                  end else if (b <= 8) m_byte[b-1] = s;
                  else begin
                     if (s && !m_ctrl[0]) begin m_buf = m_byte; set_ri = 1; end
                     m_rt = -1;
                  end
               end
            end
         end
         acc = we && addr && ok && !m_busy;
         if (m_busy) begin
            if (tick) begin
               m_k++;
               if (m_k == 9 * OS) set_ti = 1;
               if (m_k == 10 * OS) m_busy = 0;
            end
         end else if (acc) begin
            m_busy = 1; m_k = 0; m_tx = wdata;
         end
         if (m_busy) begin
            idx = m_k / OS;
            if (idx == 0) m_txd = 0;
            else if (idx <= 8) m_txd = m_tx[idx-1];
            else m_txd = 1;
         end else m_txd = 1;
         if (we && !addr) m_ctrl = wdata;
         if (set_ri) m_ctrl[0] = 1'b1;
         if (set_ti) m_ctrl[1] = 1'b1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (rst_n && cmp_on) begin
         chk("R3 ser_out vs model", ser_out, m_txd);
         chk("R12 irq vs model", irq, m_ctrl[0] | m_ctrl[1]);
         if (addr) chk("R7 buffer vs model", rdata, m_buf);
         else      chk("R2 control vs model", rdata, m_ctrl);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected<%0d cycles", cyc, 150000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic peek(input logic a, output logic [7:0] v);
      @(negedge clk);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input logic stopv);
      @(negedge clk);
      rx_drv = 1'b0;
      idle(BITCLK);
      for (int i = 0; i < 8; i++) begin
         rx_drv = d[i];
         idle(BITCLK);
      end
      rx_drv = stopv;
      idle(BITCLK);
      rx_drv = 1'b1;
      idle(2 * BITCLK);
   endtask

   task automatic wait_irq();
      while (!irq) @(negedge clk);
   endtask

   initial begin
      logic [7:0] v;
      idle(4);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      // R1: reset state
      peek(1'b0, v); chk("R1 control after reset", v, 8'h00);
      chk("R1 ser_out after reset", ser_out, 1);
      chk("R1 irq after reset", irq, 0);
      peek(1'b1, v); chk("R1 buffer after reset", v, 8'h00);
      // R2 readback, R12 irq from software-set flag
      wr(1'b0, 8'h6E);
      peek(1'b0, v); chk("R2 control readback", v, 8'h6E);
      chk("R12 irq with transmit flag", irq, 1);
      // R5 / R10: mode 00 blocks both directions
      wr(1'b0, 8'h10);
      wr(1'b1, 8'hA5);
      idle(3 * BITCLK);
      chk("R5 no frame in mode 00", ser_out, 1);
      send(8'h66, 1'b1);
      peek(1'b0, v); chk("R10 no reception in mode 00", v, 8'h10);
      // loopback transmit with ignored writes
      wr(1'b0, 8'h50);
      loop = 1'b1;
      wr(1'b1, 8'hA5);
      idle(20);
      wr(1'b1, 8'h3C);
      wait_irq();
      chk("R4 line high at stop start", ser_out, 1);
      peek(1'b0, v); chk("R4 transmit flag at stop", v[1], 1);
      wr(1'b1, 8'h11);
      idle(2 * BITCLK);
      peek(1'b1, v); chk("R5 mid-frame writes ignored", v, 8'hA5);
      peek(1'b0, v); chk("R7 receive flag after loopback", v[0], 1);
      idle(100);
      peek(1'b0, v); chk("R11 flags stay set", v, 8'h53);
      wr(1'b0, 8'h50);
      peek(1'b0, v); chk("R11 flags cleared by write", v, 8'h50);
      chk("R12 irq low after clear", irq, 0);
      wr(1'b1, 8'h3C);
      wait_irq();
      idle(2 * BITCLK);
      peek(1'b1, v); chk("R4 next byte accepted after stop", v, 8'h3C);
      wr(1'b0, 8'h50);
      loop = 1'b0;
      // receive path
      send(8'h5A, 1'b1);
      peek(1'b1, v); chk("R7 received byte", v, 8'h5A);
      peek(1'b0, v); chk("R7 receive flag", v, 8'h51);
      send(8'hC3, 1'b1);
      peek(1'b1, v); chk("R9 earlier byte kept", v, 8'h5A);
      wr(1'b0, 8'h50);
      send(8'h96, 1'b0);
      peek(1'b0, v); chk("R8 low stop no flag", v, 8'h50);
      peek(1'b1, v); chk("R8 low stop buffer unchanged", v, 8'h5A);
      @(negedge clk); rx_drv = 1'b0;
      idle(6);
      rx_drv = 1'b1;
      idle(4 * OS);
      peek(1'b0, v); chk("R6 false start dropped", v, 8'h50);
      send(8'h81, 1'b1);
      peek(1'b1, v); chk("R6 frame after false start", v, 8'h81);
      wr(1'b0, 8'h40);
      send(8'h24, 1'b1);
      peek(1'b0, v); chk("R10 disabled receiver", v, 8'h40);
      peek(1'b1, v); chk("R10 buffer kept while disabled", v, 8'h81);
      wr(1'b0, 8'h50);
      @(negedge clk); rx_drv = 1'b0;
      idle(4 * BITCLK);
      wr(1'b0, 8'h40);
      rx_drv = 1'b1;
      idle(8 * BITCLK);
      wr(1'b0, 8'h50);
      idle(20);
      peek(1'b0, v); chk("R10 frame abandoned", v, 8'h50);
      cmp_on = 1'b0;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule